// File: doc/BRIEF.md
# I2C Byte-Addressed SRAM Target with Upper-Region Write Lock

This block is a target on a two-wire I2C bus. It gives a bus controller byte access to an internal SRAM that is 8 bits wide and 512 or 2048 words deep. Both the clock line and the data line are sampled by a much faster system clock. The block pulls the data line low through an open-drain enable and never drives it high. It never holds the clock line, so every byte moves at the controller's pace with no wait states.

Each 7-bit target address has four parts. The upper four bits are a fixed prefix. The next two bits come from two select pins, which lets four of these blocks share one bus. The last bit chooses between two spaces: the memory and a one-byte status register. A memory transaction sends a two-byte word pointer and then streams data bytes in either direction. The pointer advances after every byte and wraps at the end of the array.

A 3-bit lock field in the status register fences off the top part of the array. Writes that land inside that part are acknowledged and then thrown away.

Top module: `sr_i2c_sram`

## Requirements
- R1: The address byte is laid out as bits[7:4] = 4'b1010, bits[3:2] = the `sel_i` pins, bit[1] = space (0 memory, 1 status) and bit[0] = direction (1 read). On a match the target pulls SDA low in the ninth clock. On any other byte it stays released and ignores the bus until the next START.
- R2: A memory write sends the pointer high byte and then the low byte (pointer = low bits of {high, low}), followed by data bytes. Each byte is acknowledged and stored at the pointer, which then increments.
- R3: A memory read returns the byte at the pointer, most significant bit first, and then increments the pointer. Reading continues while the controller acknowledges. After the controller's not-acknowledge the target leaves SDA released.
- R4: The pointer wraps from DEPTH-1 to 0 on both writes and reads.
- R5: A START seen in any state, including a repeated START in the middle of a transfer, restarts the address phase.
- R6: A STOP returns the target to idle with SDA released.
- R7: A data byte written to the status space sets the lock field from bits[2:0]. A read of the status space returns {5'b0, lock}.
- R8: A lock value n in 1..7 protects every address at or above DEPTH - (DEPTH >> (7-n)), which is the top 1/64 of the array for n=1 and the whole array for n=7. A lock value of 0 protects nothing.
- R9: A data byte aimed at a protected address is acknowledged but not stored, and the pointer still advances.
- R10: The depth is a parameter (512 or 2048) and each word holds 8 bits.
- R11: The target changes SDA only while SCL is low and never holds SCL, so back-to-back bytes run at the controller's rate.
- R12: After reset SDA is released, the lock field is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired-AND level) |
| sel_i | input | 2 | Address-select pins forming bits[3:2] of the target address |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
An SCL edge at the input changes `sda_oe` on the third rising system clock edge after it. That delay is two synchronizer stages plus the edge register, and the state register takes the decision at that third edge. The bench controller waits eight system clocks after each SCL transition before it moves SDA or reads the line. Every acknowledge and data bit is therefore read long after the target has settled. Memory and lock results are checked by reading them back in a later bus transaction. A monitor on the falling clock edge counts every change of `sda_oe` that happens while SCL is high.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } bus_st_e;

    typedef enum logic [2:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WDATA,
        PH_SDATA
    } phase_e;

    typedef struct packed {
        logic [3:0] prefix;
        logic [1:0] sel;
        logic       space;
        logic       rd;
    } dev_byte_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic [7:0] status_byte(logic [2:0] lock);
        return {5'b0, lock};
    endfunction

    function automatic phase_e next_phase(phase_e ph, logic space);
        case (ph)
            PH_DEV:  return space ? PH_SDATA : PH_AHI;
            PH_AHI:  return PH_ALO;
            PH_ALO:  return PH_WDATA;
            PH_WDATA: return PH_WDATA;
            default: return PH_SDATA;
        endcase
    endfunction

endpackage

// File: rtl/sr_bus_sense.sv
module sr_bus_sense
    import sr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    sda_s,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_p, sda_p, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_p    <= scl_s;
            sda_p    <= sda_s;
        end
    end

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_comb begin
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.start, ev.stop, ev.rise, ev.fall})); // R5

endmodule

// File: rtl/sr_prot_map.sv
module sr_prot_map #(
    parameter int AW = 9
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    lock,
    output logic          hit
);
    localparam logic [AW:0] FULL = (AW+1)'(1) << AW;

    logic [AW:0] span, base;

    always_comb begin
        span = '0;
        if (lock != 3'd0) span = FULL >> (3'd7 - lock);
        base = FULL - span;
        hit  = (lock != 3'd0) && ({1'b0, addr} >= base);
    end

    always_comb begin
        AST_FULL_LOCK: assert (lock != 3'd7 || hit);   // R8
        AST_NO_LOCK:   assert (lock != 3'd0 || !hit);  // R8
    end

endmodule

// File: rtl/sr_mem_array.sv
module sr_mem_array #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int WORDS = 1 << AW;

    logic [7:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/sr_i2c_sram.sv
module sr_i2c_sram
    import sr_pkg::*;
#(
    parameter int         DEPTH  = 512,
    parameter logic [3:0] PREFIX = DEV_PREFIX
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] sel_i,
    output logic       sda_oe
);
    localparam int AW = $clog2(DEPTH);

    bus_ev_t       ev;
    logic          sda_s;
    bus_st_e       st;
    phase_e        phase;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg, txsh, hi_byte, rdata, src;
    logic [AW-1:0] ptr;
    logic          space, rd, mack;
    logic [2:0]    lock;
    logic          prot_hit, byte_done, load_tx, ptr_step, mem_we;
    dev_byte_t     dev;

    sr_bus_sense #(.SYNC_STAGES(2)) u_sense (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .ev(ev)
    );

    sr_prot_map #(.AW(AW)) u_prot (
        .addr(ptr), .lock(lock), .hit(prot_hit)
    );

    sr_mem_array #(.AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(ptr), .wdata(shreg),
        .raddr(ptr), .rdata(rdata)
    );

    always_comb begin
        dev       = dev_byte_t'(shreg);
        src       = space ? status_byte(lock) : rdata;
        byte_done = (st == ST_RX) && ev.fall && (bitcnt == 4'd8);
        load_tx   = ev.fall && (((st == ST_ACK) && (phase == PH_DEV) && rd) ||
                                ((st == ST_TXACK) && mack));
        mem_we    = byte_done && (phase == PH_WDATA) && !prot_hit;
        ptr_step  = (byte_done && (phase == PH_WDATA)) || (load_tx && !space);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            phase   <= PH_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            hi_byte <= '0;
            ptr     <= '0;
            space   <= 1'b0;
            rd      <= 1'b0;
            mack    <= 1'b0;
            lock    <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_RX;
            phase  <= PH_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            if (ptr_step) ptr <= ptr + AW'(1);
            case (st)
                ST_RX: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        st     <= ST_ACK;
                        sda_oe <= 1'b1;
                        case (phase)
                            PH_DEV: begin
                                if (dev.prefix == PREFIX && dev.sel == sel_i) begin
                                    space <= dev.space;
                                    rd    <= dev.rd;
                                end else begin
                                    st     <= ST_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            PH_AHI:  hi_byte <= shreg;
                            PH_ALO:  ptr <= AW'({hi_byte, shreg});
                            PH_SDATA: lock <= shreg[2:0];
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (load_tx) begin
                            txsh   <= src;
                            sda_oe <= ~src[7];
                            st     <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_RX;
                            phase  <= next_phase(phase, space);
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 4'd7) begin
                            st     <= ST_TXACK;
                            sda_oe <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            txsh   <= {txsh[6:0], 1'b0};
                            sda_oe <= ~txsh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (ev.rise) mack <= ~sda_s;
                    if (ev.fall) begin
                        if (load_tx) begin
                            txsh   <= src;
                            sda_oe <= ~src[7];
                            bitcnt <= '0;
                            st     <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe); // R6
    AST_TXACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TXACK) |-> !sda_oe); // R3
    AST_SDA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!ev.fall && !ev.start && !ev.stop) |=> $stable(sda_oe)); // R11
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ptr_step && !ev.start && !ev.stop && (ptr == '1)) |=> (ptr == '0)); // R4

endmodule

// File: tb/sim_sr_i2c_sram.sv
module sim_sr_i2c_sram;
    localparam int DEPTH = 512;
    localparam int Q = 8;
    localparam logic [1:0] SEL = 2'b10;

    typedef struct packed {
        logic        wr;
        logic [10:0] a;
        logic [7:0]  d;
    } vec_t;

    localparam vec_t VT [12] = '{
        '{1'b1, 11'h000, 8'h3C}, '{1'b1, 11'h07F, 8'hA5},
        '{1'b1, 11'h0FF, 8'h81}, '{1'b1, 11'h100, 8'h7E},
        '{1'b1, 11'h020, 8'h5A}, '{1'b1, 11'h1F8, 8'h77},
        '{1'b0, 11'h1F8, 8'h77}, '{1'b0, 11'h000, 8'h3C},
        '{1'b0, 11'h100, 8'h7E}, '{1'b0, 11'h07F, 8'hA5},
        '{1'b0, 11'h020, 8'h5A}, '{1'b0, 11'h0FF, 8'h81}
    };

    logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;
    int   nchk = 0, nfail = 0, viol = 0;
    logic scl_prev = 1'b1, oe_prev = 1'b0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic all_ack;

    always #2 clk = ~clk;

    sr_i2c_sram #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sel_i(SEL), .sda_oe(sda_oe)
    );

    // R11 monitor: no SDA movement by the target while SCL stays high
    always @(negedge clk) begin
        if (!rst && scl_m && scl_prev && (sda_oe != oe_prev)) viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic tck(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_out(logic b);
        sda_m = b; tck(Q); scl_m = 1'b1; tck(2*Q); scl_m = 1'b0; tck(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tck(Q); scl_m = 1'b1; tck(Q); b = sda_line;
        tck(Q); scl_m = 1'b0; tck(Q);
    endtask

    task automatic start_c();
        sda_m = 1'b1; tck(Q); scl_m = 1'b1; tck(Q); sda_m = 1'b0; tck(Q);
        scl_m = 1'b0; tck(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tck(Q); scl_m = 1'b1; tck(Q); sda_m = 1'b1; tck(2*Q);
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_in(b[i]);
        bit_out(~mack);
    endtask

    function automatic logic [7:0] dev(logic [1:0] s, logic space, logic r);
        return {4'b1010, s, space, r};
    endfunction

    task automatic write_bytes(logic [10:0] a, int n);
        logic k;
        all_ack = 1'b1;
        start_c();
        send_byte(dev(SEL, 1'b0, 1'b0), k); all_ack &= k;
        send_byte({5'b0, a[10:8]}, k); all_ack &= k;
        send_byte(a[7:0], k); all_ack &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k); all_ack &= k;
        end
        stop_c();
    endtask

    task automatic read_bytes(logic [10:0] a, int n);
        logic k;
        all_ack = 1'b1;
        start_c();
        send_byte(dev(SEL, 1'b0, 1'b0), k); all_ack &= k;
        send_byte({5'b0, a[10:8]}, k); all_ack &= k;
        send_byte(a[7:0], k); all_ack &= k;
        start_c();
        send_byte(dev(SEL, 1'b0, 1'b1), k); all_ack &= k;
        for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
        stop_c();
    endtask

    task automatic set_lock(logic [7:0] v);
        logic k;
        start_c();
        send_byte(dev(SEL, 1'b1, 1'b0), k);
        send_byte(v, k);
        stop_c();
    endtask

    task automatic get_status(output logic [7:0] v);
        logic k;
        start_c();
        send_byte(dev(SEL, 1'b1, 1'b1), k);
        recv_byte(1'b0, v);
        stop_c();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic k;
        tck(5); rst = 1'b0; tck(5);
        chk("R12 sda released", sda_oe, 0);
        get_status(v);
        chk("R12 lock zero", v, 8'h00);

        // vector table: R2 writes, R3 random reads via repeated START (R5)
        foreach (VT[i]) begin
            if (VT[i].wr) begin
                wbuf[0] = VT[i].d;
                write_bytes(VT[i].a, 1);
                chk("R2 write acked", all_ack, 1);
            end else begin
                read_bytes(VT[i].a, 1);
                chk("R3 read data", rbuf[0], VT[i].d);
            end
        end

        // R2/R3/R5 sequential burst
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_bytes(11'h040, 3);
        read_bytes(11'h040, 3);
        chk("R5 burst acks", all_ack, 1);
        chk("R3 burst 0", rbuf[0], 8'h11);
        chk("R3 burst 1", rbuf[1], 8'h22);
        chk("R3 burst 2", rbuf[2], 8'h33);

        // R1 wrong select pins: no ack, no write
        start_c();
        send_byte(dev(2'b01, 1'b0, 1'b0), k);
        chk("R1 foreign address nack", k, 0);
        send_byte(8'h00, k); send_byte(8'h20, k); send_byte(8'hFF, k);
        stop_c();
        read_bytes(11'h020, 1);
        chk("R1 foreign write ignored", rbuf[0], 8'h5A);

        // R4/R10 wrap at DEPTH-1
        wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
        write_bytes(11'(DEPTH-1), 2);
        read_bytes(11'(DEPTH-1), 2);
        chk("R10 last word", rbuf[0], 8'hAA);
        chk("R4 wrapped to 0", rbuf[1], 8'h55);

        // R7/R8/R9 lock 1: top 8 words
        set_lock(8'h01);
        get_status(v);
        chk("R7 lock readback", v, 8'h01);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_bytes(11'h1F7, 2);
        chk("R9 protected acked", all_ack, 1);
        read_bytes(11'h1F7, 2);
        chk("R8 below base written", rbuf[0], 8'h11);
        chk("R8 base dropped", rbuf[1], 8'h77);
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
        write_bytes(11'h1FF, 2);
        read_bytes(11'h1FF, 2);
        chk("R9 dropped top", rbuf[0], 8'hAA);
        chk("R9 pointer advanced", rbuf[1], 8'hC2);

        // R8 lock 6: upper half
        set_lock(8'h06);
        wbuf[0] = 8'h66; wbuf[1] = 8'h67;
        write_bytes(11'h0FF, 2);
        read_bytes(11'h0FF, 2);
        chk("R8 half below", rbuf[0], 8'h66);
        chk("R8 half above", rbuf[1], 8'h7E);

        // R7/R8 lock 7 via 0xFF: whole array, upper bits dropped
        set_lock(8'hFF);
        get_status(v);
        chk("R7 upper bits zero", v, 8'h07);
        wbuf[0] = 8'h99;
        write_bytes(11'h000, 1);
        read_bytes(11'h000, 1);
        chk("R8 whole array locked", rbuf[0], 8'hC2);

        // R3/R6 release after NACK and STOP
        start_c();
        send_byte(dev(SEL, 1'b0, 1'b1), k);
        recv_byte(1'b0, v);
        tck(Q);
        chk("R3 released after nack", sda_oe, 0);
        stop_c();
        chk("R6 released after stop", sda_oe, 0);

        // R12 mid-run reset: lock cleared, pointer at 0
        rst = 1'b1; tck(4); rst = 1'b0; tck(4);
        get_status(v);
        chk("R12 lock cleared", v, 8'h00);
        start_c();
        send_byte(dev(SEL, 1'b0, 1'b1), k);
        recv_byte(1'b0, v);
        stop_c();
        chk("R12 pointer zero", v, 8'hC2);

        chk("R11 sda moved while scl high", viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule